// File: doc/BRIEF.md
# Block Address Translator

This block maps a 32-bit effective address to a real address through a small set of block-translation entries. Each entry pairs an upper word with a lower word. The upper word carries the effective page index, a block-length field and two state-qualified valid bits. The lower word carries the real page base and a 2-bit protection code. Software-side logic writes the entries through an index and write-enable port.

Each lookup is purely combinational. It takes the effective address, the access kind and the processor state, and it returns hit, fault and the real address in the same cycle. A miss lets a following segment or page translation stage take over. When relocation is switched off, the address passes through unchanged.

Top module: `blk_xlate`

## Requirements
- R1: After reset every entry is invalid, so a lookup with relocation on reports hit=0.
- R2: With `relocate`=0 the outputs are ra=ea, hit=1 and fault=0, whatever the entries, access or state.
- R3: An entry takes part in matching only when its supervisor-valid bit (upper bit 1) is set and `problem`=0, or when its problem-valid bit (upper bit 0) is set and `problem`=1.
- R4: The length field (upper bits 12:2) forms offset-mask bits 27:17. Mask bits 16:0 are always 1 (128 KB minimum block), and bits 31:28 are always 0.
- R5: An entry matches when (ea AND NOT mask) equals its effective page index (upper bits 27:13) placed at address bits 31:17.
- R6: On a permitted hit, ra = (ea AND mask) OR (real page base, lower bits 16:2, placed at bits 31:17). The low 17 bits of ra therefore always equal those of ea.
- R7: When several valid entries match, the entry with the lowest index is used.
- R8: Access encoding is 00 read, 01 write, 10 fetch, and 11 counts as read. Protection code (lower bits 1:0) 00 denies every access. Codes 01 and 11 deny writes only. Code 10 allows every access.
- R9: A denied access on a hit gives hit=1, fault=1 and ra=0.
- R10: With relocation on and no match, the outputs are hit=0, fault=0 and ra=0.
- R11: At a rising clock edge with `cfg_we`=1, entry `cfg_idx` takes `cfg_upper` and `cfg_lower`. Lookups after that edge use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Entry write enable |
| cfg_idx | input | 2 | Entry index to write |
| cfg_upper | input | 28 | {page index[14:0], length[10:0], sup_valid, prob_valid} |
| cfg_lower | input | 17 | {real page base[14:0], protection[1:0]} |
| relocate | input | 1 | Translation enable |
| problem | input | 1 | 1 = problem (user) state, 0 = supervisor |
| access | input | 2 | Access kind |
| ea | input | 32 | Effective address |
| hit | output | 1 | Address handled by this block |
| fault | output | 1 | Protection violation |
| ra | output | 32 | Real address |

## Verification
Every output is combinational from the stored entries, so a corrupt entry field shows at the ports on the first lookup that touches that entry after the write. A wrong length bit moves the block boundary: addresses just inside or just outside the block then miss or hit wrongly. A wrong base bit shifts the real address. A wrong protection bit flips the fault on one access kind. Overlapping entries and both processor states are exercised so that a wrong priority order or a swapped valid bit shows up as the wrong real address.

// File: rtl/blk_xlate.sv
module blk_xlate #(
  parameter int AW   = 32,
  parameter int NENT = 4,
  parameter int MINB = 17,
  parameter int LENW = 11,
  localparam int IW   = $clog2(NENT),
  localparam int EPIW = AW - MINB,
  localparam int UW   = EPIW + LENW + 2,
  localparam int LW   = EPIW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [UW-1:0] cfg_upper,
  input  logic [LW-1:0] cfg_lower,
  input  logic          relocate,
  input  logic          problem,
  input  logic [1:0]    access,
  input  logic [AW-1:0] ea,
  output logic          hit,
  output logic          fault,
  output logic [AW-1:0] ra
);
  localparam logic [1:0] ACC_WR = 2'b01;
  localparam int PADW = AW - MINB - LENW;

  logic [EPIW-1:0] epi_q [NENT];
  logic [LENW-1:0] len_q [NENT];
  logic            sv_q  [NENT];
  logic            pv_q  [NENT];
  logic [EPIW-1:0] rpn_q [NENT];
  logic [1:0]      pp_q  [NENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        epi_q[i] <= '0;
        len_q[i] <= '0;
        sv_q[i]  <= 1'b0;
        pv_q[i]  <= 1'b0;
        rpn_q[i] <= '0;
        pp_q[i]  <= '0;
      end
    end else if (cfg_we) begin
      {epi_q[cfg_idx], len_q[cfg_idx], sv_q[cfg_idx], pv_q[cfg_idx]} <= cfg_upper;
      {rpn_q[cfg_idx], pp_q[cfg_idx]} <= cfg_lower;
    end
  end

  logic [AW-1:0] msk   [NENT];
  logic [NENT-1:0] match;

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    assign msk[g]   = {{PADW{1'b0}}, len_q[g], {MINB{1'b1}}};
    assign match[g] = (problem ? pv_q[g] : sv_q[g]) &&
                      ((ea & ~msk[g]) == {epi_q[g], {MINB{1'b0}}});
  end

  logic [IW-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = NENT - 1; i >= 0; i--)
      if (match[i]) sel = IW'(i);
  end

  logic          any;
  logic          allow;
  logic [1:0]    pp;
  logic [AW-1:0] ra_blk;

  assign any    = |match;
  assign pp     = pp_q[sel];
  assign allow  = (pp == 2'b10) || ((pp != 2'b00) && (access != ACC_WR));
  assign ra_blk = (ea & msk[sel]) | {rpn_q[sel], {MINB{1'b0}}};

  assign hit   = !relocate || any;
  assign fault = relocate && any && !allow;
  assign ra    = !relocate ? ea : (any && allow) ? ra_blk : '0;
endmodule

module blk_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          relocate,
  input logic [AW-1:0] ea,
  input logic          hit,
  input logic          fault,
  input logic [AW-1:0] ra
);
  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !relocate |-> (ra == ea && hit && !fault));
  assert_fault_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (hit && ra == '0));
  assert_miss_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!fault && ra == '0));
  assert_low_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (relocate && hit && !fault) |-> (ra[16:0] == ea[16:0]));
endmodule

bind blk_xlate blk_xlate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .relocate(relocate), .ea(ea),
  .hit(hit), .fault(fault), .ra(ra)
);

// File: tb/test_blk_xlate.sv
module test_blk_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [27:0] cfg_upper = '0;
  logic [16:0] cfg_lower = '0;
  logic        relocate = 1'b0;
  logic        problem = 1'b0;
  logic [1:0]  access = '0;
  logic [31:0] ea = '0;
  logic        hit, fault;
  logic [31:0] ra;

  int vecs = 0;
  int errs = 0;
  logic [27:0] m_up [4];
  logic [16:0] m_lo [4];

  blk_xlate i_blk_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_upper(cfg_upper), .cfg_lower(cfg_lower), .relocate(relocate),
    .problem(problem), .access(access), .ea(ea),
    .hit(hit), .fault(fault), .ra(ra)
  );

  always #10 clk = ~clk;

  function automatic logic [27:0] up(input logic [14:0] epi, input logic [10:0] len,
                                     input logic sv, input logic pv);
    return {epi, len, sv, pv};
  endfunction

  function automatic logic [31:0] mask_of(input logic [27:0] u);
    return {4'b0, u[12:2], 17'h1ffff};
  endfunction

  task automatic model(output logic eh, output logic ef, output logic [31:0] er);
    logic found = 1'b0;
    int   k = 0;
    eh = 1'b1; ef = 1'b0; er = ea;
    if (relocate) begin
      for (int i = 0; i < 4; i++)
        if (!found && (problem ? m_up[i][0] : m_up[i][1]) &&
            ((ea & ~mask_of(m_up[i])) == {m_up[i][27:13], 17'b0})) begin
          found = 1'b1; k = i;
        end
      if (!found) begin
        eh = 1'b0; er = '0;
      end else if (m_lo[k][1:0] == 2'b00 ||
                   (m_lo[k][1:0] != 2'b10 && access == 2'b01)) begin
        ef = 1'b1; er = '0;
      end else
        er = (ea & mask_of(m_up[k])) | {m_lo[k][16:2], 17'b0};
    end
  endtask

  task automatic wr(input int idx, input logic [27:0] u, input logic [16:0] l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_upper = u; cfg_lower = l;
    m_up[idx] = u; m_lo[idx] = l;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input string tag, input logic rl, input logic pr,
                      input logic [1:0] ac, input logic [31:0] a);
    logic eh, ef;
    logic [31:0] er;
    @(negedge clk);
    relocate = rl; problem = pr; access = ac; ea = a;
    #5;
    model(eh, ef, er);
    vecs++;
    if (hit !== eh || fault !== ef || ra !== er) begin
      errs++;
      $display("FAIL %s ea=%h: got hit=%b fault=%b ra=%h, expected hit=%b fault=%b ra=%h",
               tag, a, hit, fault, ra, eh, ef, er);
    end
  endtask

  initial begin
    #3_000_000;
    errs++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed);
    for (int i = 0; i < 4; i++) begin m_up[i] = '0; m_lo[i] = '0; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    look("R1 reset miss", 1, 0, 2'b00, 32'h1001_2345);
    look("R10 reset miss problem", 1, 1, 2'b10, 32'h0000_0000);
    look("R2 passthrough", 0, 1, 2'b01, 32'hdead_beef);
    wr(0, up(15'h0800, 11'h000, 1, 0), {15'h1000, 2'b10});
    look("R11 R6 write then hit", 1, 0, 2'b00, 32'h1001_2345);
    look("R3 problem state ignores sup-only entry", 1, 1, 2'b00, 32'h1001_2345);
    look("R5 just past 128KB misses", 1, 0, 2'b00, 32'h1002_0000);
    wr(0, up(15'h0800, 11'h001, 1, 0), {15'h1000, 2'b10});
    look("R4 256KB block covers", 1, 0, 2'b00, 32'h1003_fffc);
    look("R4 beyond 256KB", 1, 0, 2'b00, 32'h1004_0000);
    wr(1, up(15'h0800, 11'h000, 1, 1), {15'h1800, 2'b10});
    look("R7 lowest index wins", 1, 0, 2'b00, 32'h1001_2345);
    look("R3 problem picks entry1", 1, 1, 2'b00, 32'h1001_2345);
    wr(1, up(15'h0800, 11'h000, 1, 1), {15'h1800, 2'b00});
    look("R8 R9 pp00 read fault", 1, 1, 2'b00, 32'h1000_0040);
    look("R8 pp00 fetch fault", 1, 1, 2'b10, 32'h1000_0040);
    wr(1, up(15'h0800, 11'h000, 1, 1), {15'h1800, 2'b01});
    look("R8 pp01 write fault", 1, 1, 2'b01, 32'h1000_0040);
    look("R8 pp01 fetch ok", 1, 1, 2'b10, 32'h1000_0040);
    wr(1, up(15'h0800, 11'h000, 1, 1), {15'h1800, 2'b11});
    look("R8 pp11 write fault", 1, 1, 2'b01, 32'h1000_0040);
    look("R8 pp11 code3 read ok", 1, 1, 2'b11, 32'h1000_0040);
    wr(1, up(15'h0800, 11'h000, 1, 1), {15'h1800, 2'b10});
    look("R8 pp10 write ok", 1, 1, 2'b01, 32'h1000_0040);
    for (int n = 0; n < 3000; n++) begin
      if (n % 150 == 0)
        for (int i = 0; i < 4; i++) begin
          logic [10:0] ln;
          logic [14:0] ep;
          ln = 11'((32'd1 << ($urandom % 12)) - 1);
          ep = 15'($urandom) & ~{4'b0, ln};
          wr(i, up(ep, ln, 1'($urandom), 1'($urandom)), 17'($urandom));
        end
      begin
        logic [31:0] a;
        int j;
        j = $urandom % 4;
        a = $urandom;
        if ($urandom % 4 != 0)
          a = {m_up[j][27:13], 17'b0} | (a & mask_of(m_up[j]));
        look("R3 R5 R6 R7 R8 random", ($urandom % 8) != 0, 1'($urandom),
             2'($urandom), a);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule